// File: doc/BRIEF.md
# Serial Command Decoder with Staged Configuration

This block is the slave end of a four-wire serial link that drives a voice record/playback sequencer. A host frames each transfer with an active-low select. While the select is low the host sends an 8-bit opcode, then an optional 16-bit operand, least-significant bit first. When the select is released the block decodes the frame. It then pulses one command strobe toward the sequencer, or it loads a configuration word, or it publishes a start address.

During the same frame the block returns status on its serial output. It sends an overflow flag first, then an end-of-message flag, then the sequencer's current row address. Two 16-bit configuration words are visible to the core. The first of them is staged: a write to it only fills a hidden holding register, and the holding value becomes active when the second word is written. The serial pins are oversampled in the system clock domain, so the serial clock must run well below the system clock.

Top module: `spi_cmd_ctrl`

## Requirements
- R1: MOSI is sampled on each rising SCLK edge while ss_n is low. The first bit received is bit 0 of the opcode. Bits 8 to 23 of the frame form the operand, bit 8 being operand bit 0.
- R2: Each accepted command pulses exactly one strobe for one clk cycle after ss_n returns high. The opcodes are: 0x60 power-up (stb_pwrup), 0xF0 play (stb_play), 0xB0 record (stb_rec), 0xE0 set-play (stb_setplay), 0xA0 set-record (stb_setrec) and 0xE8 set-cue (stb_setmc). At most one strobe is high in any cycle.
- R3: Set-play, set-record, set-cue and both configuration loads need exactly 24 received bits. Power-up, play and record accept either 8 or 24 bits. A frame with any other bit count has no effect.
- R4: Opcode 0x42, and 0x62 (bit 5 is don't-care), stores the operand in a hidden holding register. Neither cfg0 nor cfg1 changes.
- R5: Opcode 0x44 or 0x64 loads cfg1 with the operand. On the same clk edge it copies the holding register into cfg0.
- R6: After a set-play, set-record or set-cue frame, if cfg0 bit 0 (the ignore-address bit) is 0, addr_out takes the operand and addr_load pulses together with the strobe. If that bit is 1, the strobe still pulses, but addr_out keeps its value and addr_load stays low.
- R7: When ss_n falls, the reply is captured. MISO then presents, in this order: ovf_in, eom_in, row_addr_in bits 0 to 15, and then zeros. The output moves to the next bit on each falling SCLK edge, so bit k can be read before the k-th rising edge (counting from 0).
- R8: A frame whose opcode matches none of the encodings above changes no output and pulses no strobe.
- R9: After reset, cfg0, cfg1, addr_out and miso are 0, and no strobe or addr_load is high.
- R10: cfg0, cfg1 and addr_out change only while ss_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host |
| ss_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial status to host |
| ovf_in | input | 1 | Overflow flag from the sequencer |
| eom_in | input | 1 | End-of-message flag from the sequencer |
| row_addr_in | input | 16 | Current row address from the sequencer |
| stb_pwrup | output | 1 | Power-up command pulse |
| stb_play | output | 1 | Play command pulse |
| stb_rec | output | 1 | Record command pulse |
| stb_setplay | output | 1 | Set-play command pulse |
| stb_setrec | output | 1 | Set-record command pulse |
| stb_setmc | output | 1 | Set-cue command pulse |
| addr_load | output | 1 | Pulse when addr_out takes a new start address |
| addr_out | output | 16 | Start address for the sequencer |
| cfg0 | output | 16 | Active configuration word 0 |
| cfg1 | output | 16 | Active configuration word 1 |

## Verification
Directed frames come first. They load the holding register and check that cfg0 does not change until word 1 is written, which separates staged from direct loading. The opcode with bit 5 set tests the don't-care bit. Further frames set the ignore-address bit and confirm that set commands still strobe but do not move addr_out. Short frames are then sent: an 8-bit set-play and a 12-bit play must both abort, while an 8-bit power-up must be accepted. This tests the bit-count rule. Random frames follow, mixing valid opcodes, arbitrary bytes and bit counts from 1 to 30, with random status inputs. Comparing every MISO bit against the captured status shows whether the bit order and the shift edge are right.

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl #(
  parameter int AW      = 16,
  parameter int IAB_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          ss_n,
  input  logic          mosi,
  output logic          miso,
  input  logic          ovf_in,
  input  logic          eom_in,
  input  logic [AW-1:0] row_addr_in,
  output logic          stb_pwrup,
  output logic          stb_play,
  output logic          stb_rec,
  output logic          stb_setplay,
  output logic          stb_setrec,
  output logic          stb_setmc,
  output logic          addr_load,
  output logic [AW-1:0] addr_out,
  output logic [AW-1:0] cfg0,
  output logic [AW-1:0] cfg1
);
  localparam int OPW = 8;
  localparam int FW  = OPW + AW;
  localparam int CW  = $clog2(FW + 2);
  localparam int TW  = AW + 2;
  localparam logic [CW-1:0] CNT_SAT = CW'(FW + 1);
  localparam logic [CW-1:0] CNT_OP  = CW'(OPW);
  localparam logic [CW-1:0] CNT_FR  = CW'(FW);

  logic [2:0]      sclk_q, ss_q;
  logic [1:0]      mosi_q;
  logic [FW-1:0]   rx;
  logic [CW-1:0]   cnt;
  logic [TW-1:0]   tx;
  logic [AW-1:0]   shadow;

  wire sck_rise = sclk_q[1] & ~sclk_q[2];
  wire sck_fall = ~sclk_q[1] & sclk_q[2];
  wire sel      = ~ss_q[1];
  wire ss_fall  = ~ss_q[1] & ss_q[2];
  wire ss_rise  = ss_q[1] & ~ss_q[2];

  wire [OPW-1:0] op  = rx[OPW-1:0];
  wire [AW-1:0]  arg = rx[FW-1:OPW];
  wire len_full  = (cnt == CNT_FR);
  wire len_short = (cnt == CNT_OP) | len_full;

  wire is_pu  = op == 8'h60;
  wire is_pl  = op == 8'hF0;
  wire is_rc  = op == 8'hB0;
  wire is_sp  = op == 8'hE0;
  wire is_sr  = op == 8'hA0;
  wire is_mc  = op == 8'hE8;
  wire is_lc0 = (op & 8'hDF) == 8'h42;
  wire is_lc1 = (op & 8'hDF) == 8'h44;
  wire is_set = is_sp | is_sr | is_mc;

  wire go_short = ss_rise & len_short;
  wire go_full  = ss_rise & len_full;

  assign miso = tx[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      ss_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      ss_q   <= {ss_q[1:0], ss_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx  <= '0;
      cnt <= '0;
    end else if (ss_fall) begin
      cnt <= '0;
    end else if (sel && sck_rise) begin
      if (cnt < CNT_FR) rx[cnt] <= mosi_q[1];
      if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tx <= '0;
    else if (ss_fall)
      tx <= {row_addr_in, eom_in, ovf_in};
    else if (sel && sck_fall)
      tx <= tx >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_pwrup   <= 1'b0;
      stb_play    <= 1'b0;
      stb_rec     <= 1'b0;
      stb_setplay <= 1'b0;
      stb_setrec  <= 1'b0;
      stb_setmc   <= 1'b0;
      addr_load   <= 1'b0;
      addr_out    <= '0;
      cfg0        <= '0;
      cfg1        <= '0;
      shadow      <= '0;
    end else begin
      stb_pwrup   <= go_short & is_pu;
      stb_play    <= go_short & is_pl;
      stb_rec     <= go_short & is_rc;
      stb_setplay <= go_full & is_sp;
      stb_setrec  <= go_full & is_sr;
      stb_setmc   <= go_full & is_mc;
      addr_load   <= go_full & is_set & ~cfg0[IAB_BIT];
      if (go_full && is_set && !cfg0[IAB_BIT]) addr_out <= arg;
      if (go_full && is_lc0) shadow <= arg;
      if (go_full && is_lc1) begin
        cfg1 <= arg;
        cfg0 <= shadow;
      end
    end
  end
endmodule

module spi_cmd_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ss_n,
  input logic          stb_pwrup,
  input logic          stb_play,
  input logic          stb_rec,
  input logic          stb_setplay,
  input logic          stb_setrec,
  input logic          stb_setmc,
  input logic          addr_load,
  input logic [AW-1:0] addr_out,
  input logic [AW-1:0] cfg0,
  input logic [AW-1:0] cfg1
);
  wire [5:0] stbs = {stb_pwrup, stb_play, stb_rec, stb_setplay, stb_setrec, stb_setmc};

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stbs));
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stbs != 6'd0) |=> (stbs == 6'd0));
  assert_strobe_after_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stbs != 6'd0) |-> (ss_n && $past(ss_n)));
  assert_load_with_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |-> (stb_setplay || stb_setrec || stb_setmc));
  assert_addr_only_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_out) |-> addr_load);
  assert_cfg_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cfg0) || !$stable(cfg1) || !$stable(addr_out)) |-> ss_n);
  assert_cfg0_with_cfg1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg0) |-> ($past(ss_n) && !$past(ss_n, 2) == 1'b0));
endmodule

bind spi_cmd_ctrl spi_cmd_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_spi_cmd_ctrl.sv
module sim_spi_cmd_ctrl;
  localparam int H = 6;

  logic clk = 0, rst_n = 0, sclk = 0, ss_n = 1, mosi = 0;
  logic ovf_in = 0, eom_in = 0;
  logic [15:0] row_addr_in = '0;
  logic miso, stb_pwrup, stb_play, stb_rec, stb_setplay, stb_setrec, stb_setmc, addr_load;
  logic [15:0] addr_out, cfg0, cfg1;

  spi_cmd_ctrl u0 (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int n_stb[6];
  int n_load;
  bit done = 0;

  logic [15:0] m_cfg0 = '0, m_cfg1 = '0, m_shadow = '0, m_addr = '0;

  always @(posedge clk) begin
    if (stb_pwrup)   n_stb[0]++;
    if (stb_play)    n_stb[1]++;
    if (stb_rec)     n_stb[2]++;
    if (stb_setplay) n_stb[3]++;
    if (stb_setrec)  n_stb[4]++;
    if (stb_setmc)   n_stb[5]++;
    if (addr_load)   n_load++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // -1 none, 0..5 strobes, 6 load word 0, 7 load word 1
  function automatic int decode(input logic [7:0] op);
    case (op)
      8'h60: return 0;
      8'hF0: return 1;
      8'hB0: return 2;
      8'hE0: return 3;
      8'hA0: return 4;
      8'hE8: return 5;
      8'h42, 8'h62: return 6;
      8'h44, 8'h64: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic bit accepted(input int code, input int nbits);
    if (code < 0) return 0;
    if (code <= 2) return (nbits == 8) || (nbits == 24);
    return nbits == 24;
  endfunction

  task automatic frame(input logic [7:0] op, input logic [15:0] arg, input int nbits, input string tag);
    logic [23:0] bits = {arg, op};
    logic [17:0] stat;
    int code = decode(op);
    bit acc = accepted(code, nbits);
    int exp_stb = -1;
    bit exp_load = 0;
    int miso_bad = 0;
    logic exp_bit, got_bit;

    @(negedge clk);
    ovf_in = 1'($urandom);
    eom_in = 1'($urandom);
    row_addr_in = 16'($urandom);
    stat = {row_addr_in, eom_in, ovf_in};
    foreach (n_stb[i]) n_stb[i] = 0;
    n_load = 0;
    ss_n = 0;
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 24) ? bits[i] : 1'($urandom);
      repeat (H) @(negedge clk);
      got_bit = miso;
      exp_bit = (i < 18) ? stat[i] : 1'b0;
      if (got_bit !== exp_bit) begin
        if (miso_bad == 0)
          chk(0, $sformatf("R7 miso bit %0d (%s)", i, tag), got_bit, exp_bit);
        miso_bad++;
      end
      sclk = 1;
      repeat (H) @(negedge clk);
      sclk = 0;
    end
    if (miso_bad == 0) chk(1, "R7", 0, 0);
    repeat (H) @(negedge clk);
    ss_n = 1;
    repeat (8) @(negedge clk);

    if (acc) begin
      if (code <= 5) exp_stb = code;
      if (code >= 3 && code <= 5 && !m_cfg0[0]) begin
        exp_load = 1;
        m_addr = arg;
      end
      if (code == 6) m_shadow = arg;
      if (code == 7) begin
        m_cfg1 = arg;
        m_cfg0 = m_shadow;
      end
    end
    for (int s = 0; s < 6; s++)
      chk(n_stb[s] == ((s == exp_stb) ? 1 : 0),
          $sformatf("R2/R3/R8 strobe %0d op %0h n %0d (%s)", s, op, nbits, tag),
          n_stb[s], (s == exp_stb) ? 1 : 0);
    chk(n_load == int'(exp_load), $sformatf("R6 addr_load (%s)", tag), n_load, exp_load);
    chk(addr_out == m_addr, $sformatf("R6 addr_out (%s)", tag), addr_out, m_addr);
    chk(cfg0 == m_cfg0, $sformatf("R4/R5 cfg0 (%s)", tag), cfg0, m_cfg0);
    chk(cfg1 == m_cfg1, $sformatf("R5 cfg1 (%s)", tag), cfg1, m_cfg1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops[8] = '{8'h60, 8'hF0, 8'hB0, 8'hE0, 8'hA0, 8'hE8, 8'h42, 8'h64};
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(cfg0 == 0 && cfg1 == 0, "R9 cfg reset", {cfg0, cfg1}, 0);
    chk(addr_out == 0 && miso == 0, "R9 addr/miso reset", {addr_out, miso}, 0);
    chk({stb_pwrup, stb_play, stb_rec, stb_setplay, stb_setrec, stb_setmc, addr_load} == 0,
        "R9 strobes idle", 0, 0);

    frame(8'hE0, 16'h1234, 24, "R1 R6 set-play loads");
    frame(8'h42, 16'h0001, 24, "R4 staged word 0");
    frame(8'hA0, 16'h4321, 24, "R4 staged bit not active yet");
    frame(8'h64, 16'hBEEF, 24, "R5 word 1 commits, bit5 set");
    frame(8'hE8, 16'h5555, 24, "R6 ignore-address set");
    frame(8'h62, 16'h8000, 24, "R4 bit5 don't-care");
    frame(8'h44, 16'h0F0F, 24, "R5 commit clears ignore");
    frame(8'hE0, 16'hAAAA, 8,  "R3 short set-play aborts");
    frame(8'hF0, 16'h0000, 12, "R3 odd length aborts");
    frame(8'h60, 16'h0000, 8,  "R3 short power-up ok");
    frame(8'hB0, 16'h0000, 25, "R3 long frame aborts");
    frame(8'h13, 16'hFFFF, 24, "R8 unknown opcode");
    frame(8'hE8, 16'hC3C3, 24, "R6 set-cue");

    for (int k = 0; k < 70; k++) begin
      logic [7:0] op = ($urandom % 4 == 0) ? 8'($urandom) : ops[$urandom % 8];
      int r = $urandom % 4;
      int nb = (r == 0) ? 8 : (r == 3) ? 1 + ($urandom % 30) : 24;
      frame(op, 16'($urandom), nb, "random R1");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule